// File: doc/BRIEF.md
# Multi-Port GPIO Register Slave

This block is a 32-bit register slave on an APB-style bus that controls up to four general-purpose I/O ports. Each port has an output-value register and a per-pin direction register. It also has a read-only view of the pin levels after a two-flop synchronizer. On the pin side, every port has an output value bus, an output-enable bus and an input bus. Pad cells sit outside the block.

The number of ports and the pin count of each port are instance parameters. The pin count defaults to 32. Each port's output-value and direction words are interleaved with a 12-byte stride. The pin-level words sit in their own bank at a 4-byte stride. Bus transfers finish with no wait states.

A small bus-phase state machine follows each transfer. ST_IDLE moves to ST_SETUP when the slave is selected without enable. ST_SETUP moves to ST_ACCESS when enable arrives, stays in ST_SETUP while the slave is selected without enable, and otherwise returns to ST_IDLE. ST_ACCESS moves back to ST_SETUP on a back-to-back select, and otherwise to ST_IDLE. A register changes only on an access cycle that directly follows a setup cycle.

Top module: `gpio_multiport_regs`

## Requirements
- R1: While reset is asserted and right after it, every output-value and direction bit is 0. All pins are inputs (pin_oe = 0, pin_out = 0) and the registers read 0.
- R2: Port p (p = 0..NUM_PORTS-1) has its output-value word at byte offset 12*p. A write there sets pin_out[p] from the clock edge that ends the access, and a read returns the stored value.
- R3: Port p has its direction word at byte offset 12*p+4. A 1 bit makes the pin an output, driven as pin_oe[p] from the edge that ends the access. A 0 bit makes it an input.
- R4: The word at offset 0x50+4*p returns pin_in[p] through a two-flop synchronizer. A level applied just before a transfer's setup cycle is not yet visible in that transfer's access cycle, and it is visible one cycle later.
- R5: Bits at or above a port's configured pin count read as 0, ignore writes, and are never driven on pin_out or pin_oe.
- R6: pready is 1 in every access cycle, so every transfer takes exactly one setup and one access cycle.
- R7: An access to an unmapped offset raises pslverr in its access cycle, reads 0 and changes no register. Unmapped offsets are the gaps at 12*p+8, non-word-aligned addresses, offsets of ports at or above NUM_PORTS, and anything else outside the map.
- R8: A write held in the setup phase without enable does not change any register. Read data is 0 outside a read access cycle and on write cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access cycle |
| pready | output | 1 | Transfer complete (always 1) |
| pslverr | output | 1 | Error response for unmapped offsets |
| pin_in | input | 4x32 | Pin levels per port |
| pin_out | output | 4x32 | Output value per port |
| pin_oe | output | 4x32 | Output enable per port |

## Verification
The assertions take for granted that the bus master keeps to the protocol: enable rises only in the cycle after a select-only cycle, and the address, write flag and data stay steady across both phases. The stimulus uses one task that always drives a setup cycle, then an access cycle, then an idle cycle. The only exception is a single deliberate select-without-enable sequence that checks R8, and no assertion relies on that sequence. Pin inputs are changed only at falling edges, so the synchronizer depth is measured without races.

// File: rtl/gpio_mp_pkg.sv
package gpio_mp_pkg;
    localparam int MAX_PORTS    = 4;
    localparam int REG_W        = 32;
    localparam int PORT_STRIDE  = 12;
    localparam int DIR_OFFSET   = 4;
    localparam int LEVEL_BASE   = 'h50;
    localparam int LEVEL_STRIDE = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACCESS = 2'd2
    } bus_state_e;

    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_DATA  = 2'd1,
        SEL_DIR   = 2'd2,
        SEL_LEVEL = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/gpio_mp_decode.sv
module gpio_mp_decode
    import gpio_mp_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [1:0]        port
);
    int unsigned a;

    always_comb begin
        a    = 32'(addr);
        sel  = SEL_NONE;
        port = 2'd0;
        for (int p = 0; p < MAX_PORTS; p++) begin
            if (p < NUM_PORTS) begin
                if (a == 32'(p * PORT_STRIDE)) begin
                    sel  = SEL_DATA;
                    port = 2'(p);
                end else if (a == 32'(p * PORT_STRIDE + DIR_OFFSET)) begin
                    sel  = SEL_DIR;
                    port = 2'(p);
                end else if (a == 32'(LEVEL_BASE + p * LEVEL_STRIDE)) begin
                    sel  = SEL_LEVEL;
                    port = 2'(p);
                end
            end
        end
    end
endmodule

// File: rtl/gpio_mp_bank.sv
module gpio_mp_bank
    import gpio_mp_pkg::*;
#(
    parameter int PINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_data,
    input  logic             wr_dir,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] pin_in,
    output logic [REG_W-1:0] data_q,
    output logic [REG_W-1:0] dir_q,
    output logic [REG_W-1:0] level_q
);
    localparam logic [REG_W-1:0] MASK =
        (PINS >= REG_W) ? {REG_W{1'b1}} : ((REG_W'(1) << PINS) - REG_W'(1));

    logic [REG_W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else begin
            if (wr_data) data_q <= wdata & MASK;
            if (wr_dir)  dir_q  <= wdata & MASK;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q  <= '0;
            level_q <= '0;
        end else begin
            meta_q  <= pin_in & MASK;
            level_q <= meta_q;
        end
    end
endmodule

// File: rtl/gpio_multiport_regs.sv
module gpio_multiport_regs
    import gpio_mp_pkg::*;
#(
    parameter int          NUM_PORTS            = 4,
    parameter int unsigned PORT_PINS [MAX_PORTS] = '{32, 32, 32, 32},
    parameter int          ADDR_W               = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              psel,
    input  logic                              penable,
    input  logic                              pwrite,
    input  logic [ADDR_W-1:0]                 paddr,
    input  logic [REG_W-1:0]                  pwdata,
    output logic [REG_W-1:0]                  prdata,
    output logic                              pready,
    output logic                              pslverr,
    input  logic [MAX_PORTS-1:0][REG_W-1:0]   pin_in,
    output logic [MAX_PORTS-1:0][REG_W-1:0]   pin_out,
    output logic [MAX_PORTS-1:0][REG_W-1:0]   pin_oe
);
    bus_state_e state_q, state_d;
    reg_sel_e   sel;
    logic [1:0] port;
    logic       access_ok;
    logic [MAX_PORTS-1:0]             wr_data, wr_dir;
    logic [MAX_PORTS-1:0][REG_W-1:0]  data_all, dir_all, lvl_all;

    gpio_mp_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) u_dec (
        .addr (paddr),
        .sel  (sel),
        .port (port)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            ST_SETUP:  state_d = (psel && penable) ? ST_ACCESS :
                                 (psel ? ST_SETUP : ST_IDLE);
            ST_ACCESS: state_d = (psel && !penable) ? ST_SETUP : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign access_ok = (state_q == ST_SETUP) && psel && penable;

    // outputs: response, read data, write strobes
    always_comb begin
        pready  = 1'b1;
        prdata  = '0;
        pslverr = 1'b0;
        wr_data = '0;
        wr_dir  = '0;
        if (access_ok) begin
            unique case (sel)
                SEL_NONE:  pslverr = 1'b1;
                SEL_DATA:  if (pwrite) wr_data[port] = 1'b1;
                           else        prdata = data_all[port];
                SEL_DIR:   if (pwrite) wr_dir[port] = 1'b1;
                           else        prdata = dir_all[port];
                SEL_LEVEL: if (!pwrite) prdata = lvl_all[port];
                default:   pslverr = 1'b1;
            endcase
        end
    end

    for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
        if (p < NUM_PORTS) begin : g_live
            gpio_mp_bank #(.PINS(int'(PORT_PINS[p]))) u_bank (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_data (wr_data[p]),
                .wr_dir  (wr_dir[p]),
                .wdata   (pwdata),
                .pin_in  (pin_in[p]),
                .data_q  (data_all[p]),
                .dir_q   (dir_all[p]),
                .level_q (lvl_all[p])
            );
        end else begin : g_absent
            logic unused_in;
            assign unused_in   = ^{pin_in[p], wr_data[p], wr_dir[p]};
            assign data_all[p] = '0;
            assign dir_all[p]  = '0;
            assign lvl_all[p]  = '0;
        end
        assign pin_out[p] = data_all[p];
        assign pin_oe[p]  = dir_all[p];
    end
endmodule

// File: rtl/gpio_multiport_regs_chk.sv
module gpio_multiport_regs_chk
    import gpio_mp_pkg::*;
#(
    parameter int          NUM_PORTS            = 4,
    parameter int unsigned PORT_PINS [MAX_PORTS] = '{32, 32, 32, 32}
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            psel,
    input logic                            penable,
    input logic                            pwrite,
    input logic [REG_W-1:0]                prdata,
    input logic                            pslverr,
    input logic [MAX_PORTS-1:0][REG_W-1:0] pin_out,
    input logic [MAX_PORTS-1:0][REG_W-1:0] pin_oe
);
    // R7: the error response only appears in an access cycle
    p_err_in_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (psel && penable));

    // R7: an errored access returns zero data
    p_err_zero_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> (prdata == '0));

    // R2: output values move only after a write access
    p_out_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |=> $stable(pin_out));

    // R3: output enables move only after a write access
    p_oe_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && pwrite) |=> $stable(pin_oe));

    // R8: read data stays zero outside read access cycles
    p_idle_rdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(psel && penable && !pwrite) |-> (prdata == '0));

    for (genvar p = 0; p < MAX_PORTS; p++) begin : g_hi
        if (p >= NUM_PORTS) begin : g_off
            p_absent_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (pin_out[p] == '0) && (pin_oe[p] == '0));
        end else if (PORT_PINS[p] < REG_W) begin : g_narrow
            p_high_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
                ((pin_out[p] >> PORT_PINS[p]) == '0) &&
                ((pin_oe[p]  >> PORT_PINS[p]) == '0));
        end
    end
endmodule

bind gpio_multiport_regs gpio_multiport_regs_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_PINS (PORT_PINS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .prdata  (prdata),
    .pslverr (pslverr),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/gpio_multiport_regs_test.sv
module gpio_multiport_regs_test;
    import gpio_mp_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NPORTS     = 3;
    localparam int unsigned PINS [MAX_PORTS] = '{32, 16, 5, 32};

    typedef struct packed {
        logic [3:0]  req;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        err;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'd2, 1'b1, 8'h00, 32'hA5A5_5A5A, 32'h0,          1'b0}, // R2 write A data
        '{4'd2, 1'b0, 8'h00, 32'h0,         32'hA5A5_5A5A, 1'b0}, // R2 readback
        '{4'd5, 1'b1, 8'h10, 32'hFFFF_1234, 32'h0,          1'b0}, // R5 B dir, 16 pins
        '{4'd5, 1'b0, 8'h10, 32'h0,         32'h0000_1234, 1'b0}, // R5
        '{4'd5, 1'b1, 8'h0C, 32'h1234_ABCD, 32'h0,          1'b0}, // R5 B data
        '{4'd5, 1'b0, 8'h0C, 32'h0,         32'h0000_ABCD, 1'b0}, // R5
        '{4'd5, 1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0,          1'b0}, // R5 C data, 5 pins
        '{4'd5, 1'b0, 8'h18, 32'h0,         32'h0000_001F, 1'b0}, // R5
        '{4'd3, 1'b1, 8'h1C, 32'h0000_0015, 32'h0,          1'b0}, // R3 C dir
        '{4'd3, 1'b0, 8'h1C, 32'h0,         32'h0000_0015, 1'b0}, // R3
        '{4'd3, 1'b0, 8'h04, 32'h0,         32'h0,          1'b0}, // R3 A dir untouched
        '{4'd7, 1'b0, 8'h24, 32'h0,         32'h0,          1'b1}, // R7 absent port D
        '{4'd7, 1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0,          1'b1}, // R7 write absent
        '{4'd7, 1'b1, 8'h08, 32'hFFFF_FFFF, 32'h0,          1'b1}, // R7 gap write
        '{4'd7, 1'b0, 8'h02, 32'h0,         32'h0,          1'b1}, // R7 unaligned
        '{4'd7, 1'b0, 8'h5C, 32'h0,         32'h0,          1'b1}, // R7 absent level
        '{4'd3, 1'b1, 8'h04, 32'h0F0F_0F0F, 32'h0,          1'b0}, // R3 A dir
        '{4'd3, 1'b0, 8'h04, 32'h0,         32'h0F0F_0F0F, 1'b0}  // R3
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic pready, pslverr;
    logic [MAX_PORTS-1:0][31:0] pin_in = '0;
    logic [MAX_PORTS-1:0][31:0] pin_out, pin_oe;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_multiport_regs #(.NUM_PORTS(NPORTS), .PORT_PINS(PINS), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apb(input logic wr, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic err);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd  = prdata;
        err = pslverr;
        check("R6 pready in access", {31'b0, pready}, 32'd1);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er;

        repeat (3) @(negedge clk);
        // R1: state during reset
        check("R1 pin_oe A in reset", pin_oe[0], 32'h0);
        check("R1 pin_out A in reset", pin_out[0], 32'h0);
        rst_n = 1'b1;
        apb(1'b0, 8'h00, 32'h0, rd, er);
        check("R1 data A after reset", rd, 32'h0);
        apb(1'b0, 8'h1C, 32'h0, rd, er);
        check("R1 dir C after reset", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            apb(VECS[i].wr, VECS[i].addr, VECS[i].wdata, rd, er);
            check($sformatf("R%0d vec %0d data", VECS[i].req, i), rd, VECS[i].exp);
            check($sformatf("R%0d vec %0d err", VECS[i].req, i), {31'b0, er}, {31'b0, VECS[i].err});
        end

        // R2 / R3 / R5 at the pins
        #1;
        check("R2 pin_out A", pin_out[0], 32'hA5A5_5A5A);
        check("R3 pin_oe A", pin_oe[0], 32'h0F0F_0F0F);
        check("R5 pin_out B", pin_out[1], 32'h0000_ABCD);
        check("R5 pin_oe B", pin_oe[1], 32'h0000_1234);
        check("R3 pin_oe C", pin_oe[2], 32'h0000_0015);
        check("R7 absent D pin_out", pin_out[3], 32'h0);
        apb(1'b0, 8'h14, 32'h0, rd, er);
        check("R7 gap B+8 errs", {31'b0, er}, 32'd1);
        apb(1'b0, 8'h0C, 32'h0, rd, er);
        check("R7 gap write left B data", rd, 32'h0000_ABCD);

        // R2: write takes effect at the edge that ends the access
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h1357_9BDF;
        @(negedge clk);
        penable = 1'b1;
        #1;
        check("R2 pin_out before commit", pin_out[0], 32'hA5A5_5A5A);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
        check("R2 pin_out after commit", pin_out[0], 32'h1357_9BDF);

        // R8: select without enable never commits
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h0;
        repeat (2) @(negedge clk);
        #1;
        check("R8 prdata zero in setup", prdata, 32'h0);
        psel = 1'b0; pwrite = 1'b0;
        @(negedge clk);
        check("R8 setup-only left pins", pin_out[0], 32'h1357_9BDF);
        apb(1'b0, 8'h00, 32'h0, rd, er);
        check("R8 setup-only left reg", rd, 32'h1357_9BDF);

        // R4: synchronizer depth
        @(negedge clk);
        pin_in[0] = 32'hCAFE_F00D;
        psel = 1'b1; pwrite = 1'b0; paddr = 8'h50;
        @(negedge clk);
        penable = 1'b1;
        #1;
        check("R4 level not after one edge", prdata, 32'h0);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        apb(1'b0, 8'h50, 32'h0, rd, er);
        check("R4 level A visible", rd, 32'hCAFE_F00D);
        pin_in[1] = 32'hDEAD_BEEF;
        pin_in[2] = 32'hFFFF_FFEA;
        repeat (3) @(negedge clk);
        apb(1'b0, 8'h54, 32'h0, rd, er);
        check("R5 level B masked", rd, 32'h0000_BEEF);
        apb(1'b0, 8'h58, 32'h0, rd, er);
        check("R5 level C masked", rd, 32'h0000_000A);
        apb(1'b1, 8'h50, 32'hFFFF_FFFF, rd, er);
        check("R7 level write no error", {31'b0, er}, 32'd0);
        apb(1'b0, 8'h00, 32'h0, rd, er);
        check("R7 level write left data", rd, 32'h1357_9BDF);

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 pin_oe A after reset", pin_oe[0], 32'h0);
        check("R1 pin_out A after reset", pin_out[0], 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        apb(1'b0, 8'h04, 32'h0, rd, er);
        check("R1 dir A reads 0", rd, 32'h0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule